// File: doc/BRIEF.md
# Biphase Mark Line Decoder

This block turns a biphase mark coded serial line back into data bits. Every bit cell opens with a level change on the line. A cell that carries a one has a second level change at its midpoint. A cell that carries a zero holds its level through the midpoint. The decoder keeps a two-phase state. While it waits, it watches the synchronised line on every clock. The first change it sees marks the start of a cell, and the decoder records the new level. The next sample-strobe pulse then takes one more sample, which must fall in the second half of the cell. A one is decoded if that sample differs from the recorded level, and a zero if it matches.

The line input is asynchronous. It passes through a synchroniser chain whose depth is a parameter, and only then is it compared. The strobe comes from whatever cell timing the surrounding logic provides. Each decoded bit appears on a held output together with a one-clock valid pulse.

Top module: `bmd_decoder`

## Requirements
- R1: During and directly after synchronous reset, `bit_o` is 1, `bit_vld_o` is 0, the decoder is in its waiting phase, and the recorded line level equals `RST_LEVEL` (default 1).
- R2: In the waiting phase, a synchronised line level that differs from the recorded level makes the decoder record that level and move to its mid-cell phase on the next clock. The first strobe after that produces a decoded bit.
- R3: In the waiting phase, strobes with an unchanged line are ignored: `bit_vld_o` stays 0 and `bit_o` keeps its last value.
- R4: In the mid-cell phase, on a strobe, `bit_o` becomes 1 if the synchronised sample differs from the recorded level and 0 if it equals it. A change and a change back before the strobe therefore decode as 0. The sample becomes the recorded level, and the decoder returns to waiting.
- R5: For any sequence of cells sent with the opening change, a mid-cell change for a 1 and none for a 0, and a strobe in the second half of each cell, the decoded bits equal the sent bits in order.
- R6: `bit_vld_o` is high for exactly one clock, in the cycle in which `bit_o` takes the newly decoded value. There is one pulse per cell, and `bit_o` does not change in any other cycle.
- R7: A line change reaches the comparison only after `SYNC_STAGES` clocks. A strobe in the same cycle as the clock edge that locks the cell start is ignored, and the strobe one cycle later is the one that decodes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Asynchronous biphase mark coded line |
| smp_stb_i | input | 1 | One-clock strobe for the mid-cell decision sample |
| bit_o | output | 1 | Last decoded bit, held between cells |
| bit_vld_o | output | 1 | One-clock pulse when `bit_o` is updated |

## Verification
The bench builds the decoder with `SYNC_STAGES` = 2 and `RST_LEVEL` = 1. It uses a 16-clock cell with the strobe at clock 12, which lets every 8-bit pattern be sent back to back. All 256 patterns run as one continuous stream, so every one-to-zero and zero-to-one neighbour pair is covered from both line levels. With the synchroniser this shallow, the exact cycle in which a strobe stops being ignored (R7) can be placed by hand. A glitch that reverts inside a cell can also be set up, to check the zero decision.

// File: rtl/bmd_pkg.sv
package bmd_pkg;

    typedef enum logic {
        PH_MID  = 1'b0,
        PH_WAIT = 1'b1
    } bmd_phase_e;

    typedef struct packed {
        bmd_phase_e phase;
        logic       held;
        logic       bit_val;
    } bmd_state_t;

    typedef struct packed {
        bmd_state_t st;
        logic       fire;
    } bmd_next_t;

    function automatic bmd_state_t bmd_reset_state(logic lvl);
        bmd_state_t s;
        s.phase   = PH_WAIT;
        s.held    = lvl;
        s.bit_val = 1'b1;
        return s;
    endfunction

    function automatic bmd_next_t bmd_step(bmd_state_t cur, logic smp, logic stb);
        bmd_next_t nx;
        nx.st   = cur;
        nx.fire = 1'b0;
        case (cur.phase)
            PH_WAIT: begin
                if (smp != cur.held) begin
                    nx.st.held  = smp;
                    nx.st.phase = PH_MID;
                end
            end
            default: begin
                if (stb) begin
                    nx.st.bit_val = smp ^ cur.held;
                    nx.st.held    = smp;
                    nx.st.phase   = PH_WAIT;
                    nx.fire       = 1'b1;
                end
            end
        endcase
        return nx;
    endfunction

endpackage

// File: rtl/bmd_sync.sv
module bmd_sync #(
    parameter int   STAGES    = 2,
    parameter logic RST_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= RST_LEVEL;
                else     chain[0] <= d_i;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= RST_LEVEL;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/bmd_core.sv
module bmd_core
    import bmd_pkg::*;
#(
    parameter logic RST_LEVEL = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       smp_i,
    input  logic       stb_i,
    output bmd_phase_e phase_o,
    output logic       held_o,
    output logic       bit_o,
    output logic       vld_o
);
    bmd_state_t st_q;
    bmd_next_t  nx;
    logic       vld_q;

    always_comb nx = bmd_step(st_q, smp_i, stb_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= bmd_reset_state(RST_LEVEL);
            vld_q <= 1'b0;
        end else begin
            st_q  <= nx.st;
            vld_q <= nx.fire;
        end
    end

    assign phase_o = st_q.phase;
    assign held_o  = st_q.held;
    assign bit_o   = st_q.bit_val;
    assign vld_o   = vld_q;
endmodule

// File: rtl/bmd_decoder.sv
module bmd_decoder
    import bmd_pkg::*;
#(
    parameter int   SYNC_STAGES = 2,
    parameter logic RST_LEVEL   = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    input  logic smp_stb_i,
    output logic bit_o,
    output logic bit_vld_o
);
    logic       sync_line;
    logic       held_line;
    bmd_phase_e cur_phase;

    bmd_sync #(
        .STAGES    (SYNC_STAGES),
        .RST_LEVEL (RST_LEVEL)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (line_i),
        .q_o (sync_line)
    );

    bmd_core #(
        .RST_LEVEL (RST_LEVEL)
    ) u_core (
        .clk     (clk),
        .rst     (rst),
        .smp_i   (sync_line),
        .stb_i   (smp_stb_i),
        .phase_o (cur_phase),
        .held_o  (held_line),
        .bit_o   (bit_o),
        .vld_o   (bit_vld_o)
    );
endmodule

// File: rtl/bmd_decoder_chk.sv
module bmd_decoder_chk
    import bmd_pkg::*;
#(
    parameter logic RST_LEVEL = 1'b1
) (
    input logic       clk,
    input logic       rst,
    input logic       smp_stb_i,
    input logic       bit_o,
    input logic       bit_vld_o,
    input logic       sync_line,
    input logic       held_line,
    input bmd_phase_e cur_phase
);
    logic rst_seen;

    always_ff @(posedge clk) rst_seen <= rst;

    // R1: state right after a reset edge
    always @(negedge clk) begin
        if (rst_seen === 1'b1) begin
            p_reset_state_r1: assert (bit_o == 1'b1 && bit_vld_o == 1'b0 &&
                                      cur_phase == PH_WAIT && held_line == RST_LEVEL)
                else $error("reset state wrong");
        end
    end

    p_lock_r2: assert property (@(posedge clk) disable iff (rst)
        (cur_phase == PH_WAIT && sync_line != held_line) |=> (cur_phase == PH_MID))
        else $error("cell start not locked");

    p_held_r3: assert property (@(posedge clk) disable iff (rst)
        !bit_vld_o |-> $stable(bit_o))
        else $error("bit changed without valid");

    p_need_stb_r4: assert property (@(posedge clk) disable iff (rst)
        bit_vld_o |-> ($past(smp_stb_i) && $past(cur_phase) == PH_MID))
        else $error("valid without strobe in mid phase");

    p_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        bit_vld_o |=> !bit_vld_o)
        else $error("valid longer than one clock");

    p_back_wait_r4: assert property (@(posedge clk) disable iff (rst)
        bit_vld_o |-> (cur_phase == PH_WAIT))
        else $error("no return to waiting");
endmodule

bind bmd_decoder bmd_decoder_chk #(.RST_LEVEL(RST_LEVEL)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_stb_i (smp_stb_i),
    .bit_o     (bit_o),
    .bit_vld_o (bit_vld_o),
    .sync_line (sync_line),
    .held_line (held_line),
    .cur_phase (cur_phase)
);

// File: tb/tb_bmd_decoder.sv
module tb_bmd_decoder;
    localparam int SYNC = 2;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_i = 1'b1;
    logic smp_stb_i = 1'b0;
    logic bit_o, bit_vld_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bmd_decoder #(.SYNC_STAGES(SYNC), .RST_LEVEL(1'b1)) dut (
        .clk(clk), .rst(rst), .line_i(line_i), .smp_stb_i(smp_stb_i),
        .bit_o(bit_o), .bit_vld_o(bit_vld_o)
    );

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // one full cell of 2*HALF clocks, strobe at clock HALF+4
    task automatic send_bit(logic b, string req);
        line_i = ~line_i;
        idle(HALF);
        if (b) line_i = ~line_i;
        idle(4);
        smp_stb_i = 1'b1;
        @(negedge clk);
        smp_stb_i = 1'b0;
        chk({req, " vld"}, bit_vld_o, 1'b1);
        chk({req, " bit"}, bit_o, b);
        @(negedge clk);
        chk("R6 pulse end", bit_vld_o, 1'b0);
        chk("R6 bit held", bit_o, b);
        idle(HALF - 6);
    endtask

    initial begin
        idle(3);
        chk("R1 bit", bit_o, 1'b1);
        chk("R1 vld", bit_vld_o, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", bit_o, 1'b1);

        // R3: idle strobes ignored
        for (int i = 0; i < 4; i++) begin
            smp_stb_i = 1'b1;
            @(negedge clk);
            smp_stb_i = 1'b0;
            chk("R3 vld", bit_vld_o, 1'b0);
            chk("R3 bit", bit_o, 1'b1);
            idle(2);
        end

        // R2 / R4: a single zero cell, then idle strobes keep the zero
        send_bit(1'b0, "R2");
        for (int i = 0; i < 3; i++) begin
            smp_stb_i = 1'b1;
            @(negedge clk);
            smp_stb_i = 1'b0;
            chk("R3 vld after zero", bit_vld_o, 1'b0);
            chk("R3 held zero", bit_o, 1'b0);
        end

        send_bit(1'b1, "R4 one");

        // R4: glitch that reverts before the strobe decodes as 0
        line_i = ~line_i;
        idle(HALF);
        line_i = ~line_i;
        idle(2);
        line_i = ~line_i;
        idle(4);
        smp_stb_i = 1'b1;
        @(negedge clk);
        smp_stb_i = 1'b0;
        chk("R4 glitch vld", bit_vld_o, 1'b1);
        chk("R4 glitch bit", bit_o, 1'b0);
        idle(HALF);

        // R7: strobe on the locking edge is ignored, the next one decodes
        line_i = ~line_i;
        idle(SYNC);
        smp_stb_i = 1'b1;
        @(negedge clk);
        chk("R7 early strobe", bit_vld_o, 1'b0);
        @(negedge clk);
        smp_stb_i = 1'b0;
        chk("R7 decode vld", bit_vld_o, 1'b1);
        chk("R7 decode bit", bit_o, 1'b0);
        idle(HALF);

        // R5: every 8-bit pattern, continuous stream
        for (int p = 0; p < 256; p++) begin
            for (int k = 7; k >= 0; k--) begin
                send_bit(p[k], "R5");
            end
        end

        idle(4);
        chk("R6 quiet at end", bit_vld_o, 1'b0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule